// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Standby Wakeup

This block turns an oversampled asynchronous serial line into characters of eight or nine data bits. A sample-rate tick comes from outside at OVS times the bit rate. Every bit cell is sampled three times around its centre, and the majority of those three samples gives the bit value. The block checks each character for line noise, a bad stop bit and, when parity is enabled, a parity mismatch. It also reports overrun when a character finishes while the previous one has not been collected. The received byte, the ninth data bit, the status flags and one combined interrupt are outputs. A single acknowledge strobe collects the current character and its flags.

A standby mode lets a receiver ignore traffic addressed to other stations on a shared line. While in standby, completed characters are dropped and the interrupt output is held low. Standby ends in one of two ways, chosen by a select input. In address-mark mode it ends when a character arrives whose most significant data bit is 1. In idle-line mode it ends when the line stays high for one full character time. Leaving standby clears the standby state without any action from the host.

The synchronizer depth and an optional output register for the interrupt are parameters. With the defaults, the interrupt follows the flags combinationally.

Top module: `uart_wake_rx`

## Requirements
- R1: After reset, every data and flag output is 0, `standby_o` is 0 and `irq_o` is 0.
- R2: Bits are sent LSB first. A frame is one start bit, then the data field, then an optional parity bit, then one stop bit, each OVS ticks long. A start is a tick that samples the line low after a tick that sampled it high. Each bit takes the majority of the samples at phases OVS/2-1, OVS/2 and OVS/2+1. If the start bit's majority is high, the start is dropped and no character is produced. Otherwise `data_o` takes data bits 7..0 and `ready_o` is set.
- R3: When `nine_bit_i`=1 the data field is 9 bits, and its bit 8 appears on `bit8_o` in the same cycle that `data_o` loads. When `nine_bit_i`=0 the data field is 8 bits and `bit8_o` is a copy of data bit 7.
- R4: With `par_en_i`=1, a parity bit follows the data field. It is chosen so that the number of ones over the data field plus the parity bit is even (`par_odd_i`=0) or odd (`par_odd_i`=1). A mismatch sets `par_err_o`. With `par_en_i`=0, `par_err_o` stays 0.
- R5: If the three samples of any bit in a frame do not all agree, `noise_o` is set.
- R6: A stop bit whose majority is 0 sets `frame_o`. The character is still delivered.
- R7: If a character is accepted while `ready_o`=1, `ovr_o` is set. `data_o`, `bit8_o` and the other flags keep their earlier values.
- R8: A one-cycle `ack_i` pulse clears `ready_o`, `ovr_o`, `noise_o`, `frame_o` and `par_err_o`.
- R9: `irq_o` is the OR of each flag ANDed with its own enable (ready, overrun, noise, framing, parity). It is forced to 0 while `standby_o`=1.
- R10: A `standby_req_i` pulse sets `standby_o`. Characters that complete during standby do not change `data_o`, `bit8_o` or any flag, except the waking character of R11.
- R11: With `wake_addr_i`=1, a character whose most significant data bit is 1 clears `standby_o` and is delivered like a normal character. The most significant bit is bit 8 in 9-bit mode and bit 7 in 8-bit mode.
- R12: With `wake_addr_i`=0, standby is cleared once the line has been sampled high on (2 + data bits + parity bit) × OVS consecutive ticks. A run that was already complete when standby was requested does not count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Sample-rate strobe, OVS per bit time |
| rxd_i | input | 1 | Serial line, idle high |
| nine_bit_i | input | 1 | 1 selects a 9-bit data field |
| par_en_i | input | 1 | 1 adds a parity bit after the data field |
| par_odd_i | input | 1 | 1 selects odd parity, 0 even |
| wake_addr_i | input | 1 | Wake method: 1 address mark, 0 idle line |
| standby_req_i | input | 1 | Pulse that enters standby |
| ack_i | input | 1 | Pulse that collects the character and clears flags |
| ie_ready_i | input | 1 | Interrupt enable for data ready |
| ie_ovr_i | input | 1 | Interrupt enable for overrun |
| ie_noise_i | input | 1 | Interrupt enable for noise |
| ie_frame_i | input | 1 | Interrupt enable for framing error |
| ie_par_i | input | 1 | Interrupt enable for parity error |
| data_o | output | DATA_W | Received data bits 7..0 |
| bit8_o | output | 1 | Ninth data bit, or a copy of bit 7 in 8-bit mode |
| ready_o | output | 1 | A character is waiting |
| ovr_o | output | 1 | Overrun flag |
| noise_o | output | 1 | Noise flag |
| frame_o | output | 1 | Framing error flag |
| par_err_o | output | 1 | Parity error flag |
| standby_o | output | 1 | Receiver is in standby |
| irq_o | output | 1 | Combined receiver interrupt |

## Verification
A character's data and flags appear one clock after the tick that takes the OVS/2+1 sample of its stop bit. An address-mark wake happens in that same cycle. An idle wake comes one clock after the tick that completes the high run. An acknowledge or a standby request takes effect at the next clock edge. The bench drives the line one sample per tick, so sample phase p of each cell is known. It checks a frame only after driving the rest of the stop cell and one more idle tick, which is several ticks after the results are due. It checks acknowledge and standby effects two falling edges after the pulse. For idle wake, it checks once at a point well short of the required run and once well past it, so neither check sits on the boundary tick.

// File: rtl/uwr_pkg.sv
package uwr_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_START,
      ST_DATA,
      ST_PAR,
      ST_STOP
   } rx_state_e;

   function automatic logic vote3(input logic a, input logic b, input logic c);
      return (a & b) | (a & c) | (b & c);
   endfunction

   function automatic logic split3(input logic a, input logic b, input logic c);
      return !((a == b) && (b == c));
   endfunction

endpackage

// File: rtl/uwr_sync.sv
module uwr_sync #(
   parameter int   STAGES    = 2,
   parameter logic RESET_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);

   generate
      if (STAGES < 0) begin : g_bad_stages
         $error("uwr_sync: STAGES must not be negative");
      end

      if (STAGES == 0) begin : g_bypass
         assign q_o = d_i;
      end else begin : g_chain
         logic [STAGES-1:0] chain_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               chain_q <= {STAGES{RESET_VAL}};
            end else if (STAGES == 1) begin
               chain_q[0] <= d_i;
            end else begin
               chain_q <= {chain_q[STAGES-2:0], d_i};
            end
         end
         assign q_o = chain_q[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/uwr_bit_engine.sv
module uwr_bit_engine
   import uwr_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int OVS    = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_i,
   input  logic              rx_i,
   input  logic              nine_bit_i,
   input  logic              par_en_i,
   input  logic              par_odd_i,
   output logic              done_o,
   output logic [DATA_W:0]   word_o,
   output logic              msb_o,
   output logic              fe_o,
   output logic              nf_o,
   output logic              pe_o
);

   localparam int PH_W  = $clog2(OVS);
   localparam int IDX_W = $clog2(DATA_W + 1);
   localparam int SMP_B = OVS / 2;
   localparam int SMP_A = SMP_B - 1;
   localparam int SMP_C = SMP_B + 1;

   generate
      if (OVS < 8) begin : g_bad_ovs
         $error("uwr_bit_engine: OVS must be at least 8");
      end
      if (DATA_W < 2) begin : g_bad_width
         $error("uwr_bit_engine: DATA_W must be at least 2");
      end
   endgenerate

   rx_state_e        state_q;
   logic [PH_W-1:0]  phase_q;
   logic [IDX_W-1:0] idx_q;
   logic [DATA_W:0]  shreg_q;
   logic             smp_a_q;
   logic             smp_b_q;
   logic             par_q;
   logic             noise_q;
   logic             rx_last_q;
   logic             nine_q;
   logic             pen_q;
   logic             odd_q;
   logic             done_q;
   logic             fe_q;
   logic             nf_q;
   logic             pe_q;

   logic             maj;
   logic             noisy;
   logic             at_mid;
   logic             at_end;
   logic             last_idx;

   always_comb begin
      maj      = vote3(smp_a_q, smp_b_q, rx_i);
      noisy    = split3(smp_a_q, smp_b_q, rx_i);
      at_mid   = (phase_q == PH_W'(SMP_C));
      at_end   = (phase_q == PH_W'(OVS - 1));
      last_idx = nine_q ? (idx_q == IDX_W'(DATA_W)) : (idx_q == IDX_W'(DATA_W - 1));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         phase_q   <= '0;
         idx_q     <= '0;
         shreg_q   <= '0;
         smp_a_q   <= 1'b1;
         smp_b_q   <= 1'b1;
         par_q     <= 1'b0;
         noise_q   <= 1'b0;
         rx_last_q <= 1'b1;
         nine_q    <= 1'b0;
         pen_q     <= 1'b0;
         odd_q     <= 1'b0;
         done_q    <= 1'b0;
         fe_q      <= 1'b0;
         nf_q      <= 1'b0;
         pe_q      <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (tick_i) begin
            rx_last_q <= rx_i;
            if (state_q == ST_IDLE) begin
               if (!rx_i && rx_last_q) begin
                  state_q <= ST_START;
                  phase_q <= PH_W'(1);
                  idx_q   <= '0;
                  shreg_q <= '0;
                  noise_q <= 1'b0;
                  nine_q  <= nine_bit_i;
                  pen_q   <= par_en_i;
                  odd_q   <= par_odd_i;
               end
            end else begin
               if (phase_q == PH_W'(SMP_A)) smp_a_q <= rx_i;
               if (phase_q == PH_W'(SMP_B)) smp_b_q <= rx_i;
               phase_q <= at_end ? '0 : phase_q + PH_W'(1);

               if (at_mid) begin
                  unique case (state_q)
                     ST_START: begin
                        if (maj) state_q <= ST_IDLE;
                        else     noise_q <= noise_q | noisy;
                     end
                     ST_DATA: begin
                        shreg_q[idx_q] <= maj;
                        noise_q        <= noise_q | noisy;
                     end
                     ST_PAR: begin
                        par_q   <= maj;
                        noise_q <= noise_q | noisy;
                     end
                     ST_STOP: begin
                        done_q  <= 1'b1;
                        fe_q    <= !maj;
                        nf_q    <= noise_q | noisy;
                        pe_q    <= pen_q && ((^shreg_q ^ par_q) != odd_q);
                        state_q <= ST_IDLE;
                     end
                     default: state_q <= ST_IDLE;
                  endcase
               end

               if (at_end) begin
                  unique case (state_q)
                     ST_START: state_q <= ST_DATA;
                     ST_DATA: begin
                        if (last_idx) state_q <= pen_q ? ST_PAR : ST_STOP;
                        else          idx_q   <= idx_q + IDX_W'(1);
                     end
                     ST_PAR:  state_q <= ST_STOP;
                     default: ;
                  endcase
               end
            end
         end
      end
   end

   assign done_o = done_q;
   assign word_o = shreg_q;
   assign msb_o  = nine_q ? shreg_q[DATA_W] : shreg_q[DATA_W-1];
   assign fe_o   = fe_q;
   assign nf_o   = nf_q;
   assign pe_o   = pe_q;

   AST_DONE_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |-> $past(tick_i)); // R2
   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |=> !done_q); // R2
   AST_EIGHT_BIT_TOP_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (done_q && !nine_q) |-> !shreg_q[DATA_W]); // R3
   AST_NO_PARITY_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
      (done_q && !pen_q) |-> !pe_q); // R4

endmodule

// File: rtl/uwr_idle_det.sv
module uwr_idle_det #(
   parameter int DATA_W = 8,
   parameter int OVS    = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick_i,
   input  logic rx_i,
   input  logic nine_bit_i,
   input  logic par_en_i,
   output logic hit_o
);

   localparam int BASE_BITS = DATA_W + 2;
   localparam int MAX_TICKS = (BASE_BITS + 2) * OVS;
   localparam int CNT_W     = $clog2(MAX_TICKS + 1);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] limit;

   always_comb begin
      limit = CNT_W'((BASE_BITS + 32'(nine_bit_i) + 32'(par_en_i)) * OVS);
      hit_o = tick_i && rx_i && (cnt_q == limit - CNT_W'(1));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (tick_i) begin
         if (!rx_i)             cnt_q <= '0;
         else if (cnt_q < limit) cnt_q <= cnt_q + CNT_W'(1);
      end
   end

   AST_IDLE_HIT_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
      hit_o |=> !hit_o); // R12

endmodule

// File: rtl/uwr_status.sv
module uwr_status #(
   parameter int DATA_W  = 8,
   parameter bit IRQ_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              done_i,
   input  logic [DATA_W:0]   word_i,
   input  logic              msb_i,
   input  logic              fe_i,
   input  logic              nf_i,
   input  logic              pe_i,
   input  logic              wake_addr_i,
   input  logic              standby_req_i,
   input  logic              idle_hit_i,
   input  logic              ack_i,
   input  logic              ie_ready_i,
   input  logic              ie_ovr_i,
   input  logic              ie_noise_i,
   input  logic              ie_frame_i,
   input  logic              ie_par_i,
   output logic [DATA_W-1:0] data_o,
   output logic              bit8_o,
   output logic              ready_o,
   output logic              ovr_o,
   output logic              noise_o,
   output logic              frame_o,
   output logic              par_o,
   output logic              standby_o,
   output logic              irq_o
);

   localparam int NSRC = 5;

   logic [DATA_W-1:0] data_q;
   logic              bit8_q;
   logic              ready_q;
   logic              ovr_q;
   logic              noise_q;
   logic              frame_q;
   logic              par_q;
   logic              standby_q;

   logic              addr_wake;
   logic              idle_wake;
   logic              accept;
   logic              held;
   logic [NSRC-1:0]   src;
   logic [NSRC-1:0]   ena;
   logic              irq_raw;

   always_comb begin
      addr_wake = standby_q && wake_addr_i && done_i && msb_i;
      idle_wake = standby_q && !wake_addr_i && idle_hit_i;
      accept    = done_i && (!standby_q || addr_wake);
      held      = ready_q && !ack_i;
      src       = {par_q, frame_q, noise_q, ovr_q, ready_q};
      ena       = {ie_par_i, ie_frame_i, ie_noise_i, ie_ovr_i, ie_ready_i};
      irq_raw   = !standby_q && (|(src & ena));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         standby_q <= 1'b0;
      end else if (standby_req_i) begin
         standby_q <= 1'b1;
      end else if (addr_wake || idle_wake) begin
         standby_q <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q  <= '0;
         bit8_q  <= 1'b0;
         ready_q <= 1'b0;
         ovr_q   <= 1'b0;
         noise_q <= 1'b0;
         frame_q <= 1'b0;
         par_q   <= 1'b0;
      end else begin
         if (ack_i) begin
            ready_q <= 1'b0;
            ovr_q   <= 1'b0;
            noise_q <= 1'b0;
            frame_q <= 1'b0;
            par_q   <= 1'b0;
         end
         if (accept) begin
            if (held) begin
               ovr_q <= 1'b1;
            end else begin
               data_q  <= word_i[DATA_W-1:0];
               bit8_q  <= msb_i;
               ready_q <= 1'b1;
               noise_q <= nf_i;
               frame_q <= fe_i;
               par_q   <= pe_i;
            end
         end
      end
   end

   generate
      if (IRQ_REG) begin : g_irq_reg
         logic irq_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) irq_q <= 1'b0;
            else        irq_q <= irq_raw;
         end
         assign irq_o = irq_q;
      end else begin : g_irq_comb
         assign irq_o = irq_raw;
      end
   endgenerate

   assign data_o    = data_q;
   assign bit8_o    = bit8_q;
   assign ready_o   = ready_q;
   assign ovr_o     = ovr_q;
   assign noise_o   = noise_q;
   assign frame_o   = frame_q;
   assign par_o     = par_q;
   assign standby_o = standby_q;

   AST_FLAGS_NEED_READY: assert property (@(posedge clk) disable iff (!rst_n)
      (ovr_q || noise_q || frame_q || par_q) |-> ready_q); // R8
   AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_i && !done_i) |=> (!ready_q && !ovr_q)); // R8
   AST_OVR_KEEPS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      (ready_q && !ack_i && done_i && !standby_q) |=> (ovr_q && $stable(data_q))); // R7
   AST_STBY_DISCARD: assert property (@(posedge clk) disable iff (!rst_n)
      (standby_q && !(done_i && wake_addr_i && msb_i)) |=> $stable(data_q)); // R10
   AST_ADDR_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
      (standby_q && wake_addr_i && done_i && msb_i && !standby_req_i) |=> !standby_q); // R11
   AST_IDLE_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
      (standby_q && !wake_addr_i && idle_hit_i && !standby_req_i) |=> !standby_q); // R12
   AST_STBY_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      standby_req_i |=> standby_q); // R10

endmodule

// File: rtl/uart_wake_rx.sv
module uart_wake_rx #(
   parameter int DATA_W      = 8,
   parameter int OVS         = 16,
   parameter int SYNC_STAGES = 2,
   parameter bit IRQ_REG     = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_i,
   input  logic              rxd_i,
   input  logic              nine_bit_i,
   input  logic              par_en_i,
   input  logic              par_odd_i,
   input  logic              wake_addr_i,
   input  logic              standby_req_i,
   input  logic              ack_i,
   input  logic              ie_ready_i,
   input  logic              ie_ovr_i,
   input  logic              ie_noise_i,
   input  logic              ie_frame_i,
   input  logic              ie_par_i,
   output logic [DATA_W-1:0] data_o,
   output logic              bit8_o,
   output logic              ready_o,
   output logic              ovr_o,
   output logic              noise_o,
   output logic              frame_o,
   output logic              par_err_o,
   output logic              standby_o,
   output logic              irq_o
);

   logic            rx_s;
   logic            done;
   logic [DATA_W:0] word;
   logic            msb;
   logic            fe;
   logic            nf;
   logic            pe;
   logic            idle_hit;

   uwr_sync #(
      .STAGES    (SYNC_STAGES),
      .RESET_VAL (1'b1)
   ) i_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (rxd_i),
      .q_o   (rx_s)
   );

   uwr_bit_engine #(
      .DATA_W (DATA_W),
      .OVS    (OVS)
   ) i_engine (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick_i     (tick_i),
      .rx_i       (rx_s),
      .nine_bit_i (nine_bit_i),
      .par_en_i   (par_en_i),
      .par_odd_i  (par_odd_i),
      .done_o     (done),
      .word_o     (word),
      .msb_o      (msb),
      .fe_o       (fe),
      .nf_o       (nf),
      .pe_o       (pe)
   );

   uwr_idle_det #(
      .DATA_W (DATA_W),
      .OVS    (OVS)
   ) i_idle (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick_i     (tick_i),
      .rx_i       (rx_s),
      .nine_bit_i (nine_bit_i),
      .par_en_i   (par_en_i),
      .hit_o      (idle_hit)
   );

   uwr_status #(
      .DATA_W  (DATA_W),
      .IRQ_REG (IRQ_REG)
   ) i_status (
      .clk           (clk),
      .rst_n         (rst_n),
      .done_i        (done),
      .word_i        (word),
      .msb_i         (msb),
      .fe_i          (fe),
      .nf_i          (nf),
      .pe_i          (pe),
      .wake_addr_i   (wake_addr_i),
      .standby_req_i (standby_req_i),
      .idle_hit_i    (idle_hit),
      .ack_i         (ack_i),
      .ie_ready_i    (ie_ready_i),
      .ie_ovr_i      (ie_ovr_i),
      .ie_noise_i    (ie_noise_i),
      .ie_frame_i    (ie_frame_i),
      .ie_par_i      (ie_par_i),
      .data_o        (data_o),
      .bit8_o        (bit8_o),
      .ready_o       (ready_o),
      .ovr_o         (ovr_o),
      .noise_o       (noise_o),
      .frame_o       (frame_o),
      .par_o         (par_err_o),
      .standby_o     (standby_o),
      .irq_o         (irq_o)
   );

endmodule

// File: tb/test_uart_wake_rx.sv
module test_uart_wake_rx;

   localparam int CLK_NS    = 10;
   localparam int TICK_CLKS = 4;
   localparam int OVS       = 16;
   localparam int WATCHDOG  = 190000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick = 1'b0;
   logic [1:0] div = '0;
   logic       rxd = 1'b1;
   logic       nine = 1'b0, pen = 1'b0, podd = 1'b0, wake_addr = 1'b0;
   logic       sby_req = 1'b0, ack = 1'b0;
   logic       ie_r = 1'b0, ie_o = 1'b0, ie_n = 1'b0, ie_f = 1'b0, ie_p = 1'b0;
   logic [7:0] data_o;
   logic       bit8_o, ready_o, ovr_o, noise_o, frame_o, par_err_o, standby_o, irq_o;

   int n_chk = 0;
   int n_err = 0;
   bit done_run = 1'b0;

   logic [7:0] m_data = '0;
   logic m_b8 = 0, m_rdy = 0, m_ovr = 0, m_nf = 0, m_fe = 0, m_pe = 0, m_sby = 0;

   always #(CLK_NS/2) clk = ~clk;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         div  <= '0;
         tick <= 1'b0;
      end else begin
         div  <= (div == 2'(TICK_CLKS - 1)) ? '0 : div + 2'd1;
         tick <= (div == 2'(TICK_CLKS - 1));
      end
   end

   uart_wake_rx i_uart_wake_rx (
      .clk(clk), .rst_n(rst_n), .tick_i(tick), .rxd_i(rxd),
      .nine_bit_i(nine), .par_en_i(pen), .par_odd_i(podd),
      .wake_addr_i(wake_addr), .standby_req_i(sby_req), .ack_i(ack),
      .ie_ready_i(ie_r), .ie_ovr_i(ie_o), .ie_noise_i(ie_n),
      .ie_frame_i(ie_f), .ie_par_i(ie_p),
      .data_o(data_o), .bit8_o(bit8_o), .ready_o(ready_o), .ovr_o(ovr_o),
      .noise_o(noise_o), .frame_o(frame_o), .par_err_o(par_err_o),
      .standby_o(standby_o), .irq_o(irq_o)
   );

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic exp_irq();
      return !m_sby && ((m_rdy & ie_r) | (m_ovr & ie_o) | (m_nf & ie_n) |
                        (m_fe & ie_f) | (m_pe & ie_p));
   endfunction

   task automatic check_all();
      @(negedge clk);
      @(negedge clk);
      chk("R2 data",     16'(data_o),    16'(m_data));
      chk("R3 bit8",     16'(bit8_o),    16'(m_b8));
      chk("R2 ready",    16'(ready_o),   16'(m_rdy));
      chk("R7 overrun",  16'(ovr_o),     16'(m_ovr));
      chk("R5 noise",    16'(noise_o),   16'(m_nf));
      chk("R6 framing",  16'(frame_o),   16'(m_fe));
      chk("R4 parity",   16'(par_err_o), 16'(m_pe));
      chk("R10 standby", 16'(standby_o), 16'(m_sby));
      chk("R9 irq",      16'(irq_o),     16'(exp_irq()));
   endtask

   task automatic slot(input logic v);
      do @(posedge clk); while (tick !== 1'b1);
      @(negedge clk);
      rxd = v;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) slot(1'b1);
   endtask

   task automatic do_ack();
      @(negedge clk); ack = 1'b1;
      @(negedge clk); ack = 1'b0;
      m_rdy = 0; m_ovr = 0; m_nf = 0; m_fe = 0; m_pe = 0;
   endtask

   task automatic do_standby();
      @(negedge clk); sby_req = 1'b1;
      @(negedge clk); sby_req = 1'b0;
      m_sby = 1;
   endtask

   task automatic send(input logic [8:0] d9, input logic n9, input logic pe_en,
                       input logic odd, input logic bad_par, input logic bad_stop,
                       input int glitch);
      logic bits [0:11];
      int nb;
      int k;
      logic p;
      logic msb;
      logic acc;
      nine = n9; pen = pe_en; podd = odd;
      k = 0;
      bits[k] = 1'b0; k++;
      for (int i = 0; i < (n9 ? 9 : 8); i++) begin bits[k] = d9[i]; k++; end
      p = (n9 ? ^d9 : ^d9[7:0]) ^ odd ^ bad_par;
      if (pe_en) begin bits[k] = p; k++; end
      bits[k] = !bad_stop; k++;
      nb = k;
      for (int b = 0; b < nb; b++)
         for (int s = 0; s < OVS; s++)
            slot((b == glitch && s == OVS/2) ? !bits[b] : bits[b]);
      slot(1'b1);
      msb = n9 ? d9[8] : d9[7];
      acc = !m_sby || (wake_addr && msb);
      if (m_sby && wake_addr && msb) m_sby = 0;
      if (acc) begin
         if (m_rdy) m_ovr = 1;
         else begin
            m_data = d9[7:0]; m_b8 = msb; m_rdy = 1;
            m_nf = (glitch >= 0); m_fe = bad_stop; m_pe = pe_en && bad_par;
         end
      end
   endtask

   task automatic finish_run();
      if (!done_run) begin
         done_run = 1'b1;
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   endtask

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_run();
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      // R1: reset state
      chk("R1 outputs", 16'({data_o, bit8_o, ready_o, ovr_o, noise_o, frame_o,
                              par_err_o, standby_o, irq_o}), 16'h0);
      rst_n = 1'b1;
      idle(4);

      // R2, R3: plain 8-bit character, bit8 mirrors bit 7
      send(9'h0A5, 0, 0, 0, 0, 0, -1); check_all();
      do_ack(); check_all();          // R8
      // R3, R4: 9-bit with even parity, then odd parity in error
      send(9'h13A, 1, 1, 0, 0, 0, -1); check_all();
      do_ack();
      send(9'h0C3, 1, 1, 1, 1, 0, -1); check_all();
      do_ack();
      // R2: false start is dropped
      for (int i = 0; i < 4; i++) slot(1'b0);
      idle(40); check_all();
      // R5: one sample of data bit 3 flipped
      send(9'h05A, 0, 0, 0, 0, 0, 4); check_all();
      do_ack();
      // R6 then R7: bad stop, then a second frame without ack
      send(9'h033, 0, 0, 0, 0, 1, -1); check_all();
      send(9'h0EE, 0, 0, 0, 0, 0, -1); check_all();
      do_ack(); check_all();          // R8

      // R9, R10, R11: address-mark standby
      ie_r = 1'b1;
      send(9'h011, 0, 0, 0, 0, 0, -1); check_all();
      wake_addr = 1'b1;
      do_standby(); check_all();
      send(9'h005, 0, 0, 0, 0, 0, -1); check_all();
      do_ack();
      send(9'h085, 0, 0, 0, 0, 0, -1); check_all();
      do_ack();
      do_standby();
      send(9'h0FF, 1, 0, 0, 0, 0, -1); check_all();   // R11: bit 8 is MSB in 9-bit mode
      send(9'h100, 1, 0, 0, 0, 0, -1); check_all();
      do_ack();

      // R12: idle-line wake, 10 bits x OVS = 160 ticks
      wake_addr = 1'b0;
      do_standby();
      send(9'h000, 0, 0, 0, 0, 0, -1); check_all();
      idle(10*OVS - 48); check_all();
      idle(64);
      m_sby = 0;
      check_all();
      send(9'h03C, 0, 0, 0, 0, 0, -1); check_all();
      do_ack();

      // random mix
      for (int it = 0; it < 40; it++) begin
         logic [8:0] d9;
         logic n9, pe_en, odd, bp, bs;
         int nbits, gl;
         d9    = 9'($urandom);
         n9    = 1'($urandom);
         pe_en = 1'($urandom);
         odd   = 1'($urandom);
         bp    = pe_en && ($urandom % 8 == 0);
         bs    = ($urandom % 8 == 0);
         nbits = 2 + (n9 ? 9 : 8) + (pe_en ? 1 : 0);
         gl    = ($urandom % 6 == 0) ? int'($urandom % nbits) : -1;
         {ie_r, ie_o, ie_n, ie_f, ie_p} = 5'($urandom);
         wake_addr = 1'($urandom);
         if ($urandom % 4 != 0) do_ack();
         send(d9, n9, pe_en, odd, bp, bs, gl);
         check_all();
      end

      finish_run();
   end

endmodule